// File: doc/BRIEF.md
# Multiplierless Bit-Plane FIR Filter

This block is a 16-tap FIR filter for unsigned sample streams that uses no multipliers. Every accepted sample is pushed into a tap window made of the incoming sample and fifteen delay registers. The window is then cut into bit planes. For one bit position, each tap whose sample has a 1 there adds its coefficient to that plane's partial sum. The planes are then combined by shifting each partial sum left by its bit position and adding the results. The output is the ordinary convolution of the coefficient set with the most recent samples. It is computed only with adders, selects and wiring shifts.

The coefficient set is fixed when the block is elaborated, through a packed parameter. Coefficient i sits in bits `[i*CW +: CW]`. Samples arrive with a valid strobe, and nothing moves on cycles where that strobe is low. Each accepted sample yields exactly one result, flagged by an output valid, two clock edges later. With the default sizes (4-bit samples, 4-bit coefficients, 16 taps) the output is 13 bits wide. That is more than the worst-case sum needs.

Top module: `dafir_filter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears the delay registers, the partial-sum stage and the outputs. After reset, `out_valid` is 0 and `out_data` is 0. The first result after reset depends only on the first accepted sample, because every older tap reads as zero.
- R2: For every accepted sample x(n), the result equals the sum over i = 0..15 of h_i · x(n−i). Here h_i is bits `[i*4 +: 4]` of `COEFS`, and x(n−i) is the i-th earlier accepted sample (zero if fewer than i samples were accepted since reset). All values are unsigned.
- R3: The output never wraps. With every sample at 15, the result equals 15 times the sum of all coefficients, and no result exceeds that bound.
- R4: A sample accepted at rising edge t (with `in_valid` = 1) makes `out_valid` high for exactly the cycle that follows edge t+1, carrying that sample's result. There is one output pulse per accepted sample.
- R5: On a cycle with `in_valid` = 0, `in_data` is ignored. The taps do not shift, and two edges later `out_valid` is 0. Later results are as if the idle cycle never occurred.
- R6: Bit plane b is weighted by 2^b. A lone sample of value 2^b (b = 0..3) followed by zeros produces the output sequence h_0·2^b, h_1·2^b, …, h_15·2^b.
- R7: While `out_valid` is 0, `out_data` keeps the last result, or 0 if there has been none since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | 4 | Unsigned input sample |
| out_valid | output | 1 | High for one cycle per produced result |
| out_data | output | 13 | Unsigned filter result |

## Verification
The bench targets the following corner cases, each of which a faulty design would get wrong in a visible way.

- **Single-bit impulses, one per bit plane.** A wrong plane weight or a swapped plane scales the impulse response by the wrong power of two. A wrong tap order reverses it.
- **A long run of all-ones samples.** A result register that is too narrow, or a partial sum that is too narrow, wraps below the expected maximum.
- **Idle cycles carrying garbage data, including long gaps between accepted samples.** A delay line that shifts on every clock corrupts later sums. A valid pipeline that ignores the strobe produces extra pulses. An output register that is loaded unconditionally breaks the hold behaviour.
- **A reset in the middle of a stream.** Stale taps left behind by the reset show up in the first result after it.

// File: rtl/dafir_pkg.sv
// Package dafir_pkg
// Shared sizing helpers for the bit-plane FIR filter.
// Assumes NTAPS*CW fits in MAX_COEF_BITS so that a coefficient vector can be
// passed to the constant functions below.
package dafir_pkg;

    localparam int MAX_COEF_BITS = 1024;

    // Width of one bit-plane partial sum: room for NTAPS coefficients.
    function automatic int psum_width(input int ntaps, input int cw);
        return cw + $clog2(ntaps + 1);
    endfunction

    // Width of the filter result: full product width plus tap growth plus margin.
    function automatic int out_width(input int ntaps, input int dw, input int cw);
        return dw + cw + $clog2(ntaps) + 1;
    endfunction

    // Sum of all unsigned coefficients packed CW bits apiece.
    function automatic int coef_total(input logic [MAX_COEF_BITS-1:0] coefs,
                                      input int ntaps, input int cw);
        int total;
        total = 0;
        for (int i = 0; i < ntaps; i++) begin
            for (int b = 0; b < cw; b++) begin
                if (coefs[i*cw + b]) total = total + (1 << b);
            end
        end
        return total;
    endfunction

endpackage

// File: rtl/dafir_delay_line.sv
// Module dafir_delay_line
// Holds the NTAPS-1 most recent accepted samples and presents the full tap
// window {older samples..., current sample}. Tap 0 is the live input.
// Assumes NTAPS >= 2. The line shifts only when adv is high; rst_n is a
// synchronous active-low clear.
module dafir_delay_line #(
    parameter int NTAPS = 16,
    parameter int DW    = 4,
    localparam int RW   = (NTAPS - 1) * DW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic [DW-1:0]       din,
    output logic [NTAPS*DW-1:0] taps
);

    logic [RW-1:0] hist_q;

    // Shift the stored history by one sample on each accepted input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (adv) begin
            if (RW > DW) begin
                hist_q <= {hist_q[RW-DW-1:0], din};
            end else begin
                hist_q <= din;
            end
        end
    end

    // Tap i lives at bits [i*DW +: DW]; tap 0 is the sample being accepted.
    assign taps = {hist_q, din};

endmodule

// File: rtl/dafir_plane_sum.sv
// Module dafir_plane_sum
// Forms the partial sum for one bit plane: every tap whose bit is set adds
// its coefficient. The sum is registered when en is high.
// Assumes unsigned coefficients packed CW bits each in COEFS, tap i at
// bits [i*CW +: CW].
module dafir_plane_sum #(
    parameter int                    NTAPS = 16,
    parameter int                    CW    = 4,
    parameter logic [NTAPS*CW-1:0]   COEFS = '0,
    localparam int                   PSW   = dafir_pkg::psum_width(NTAPS, CW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [NTAPS-1:0] plane_bits,
    output logic [PSW-1:0]   psum_q
);

    logic [PSW-1:0] psum_d;

    // Select-and-add: a 1 bit in tap i contributes coefficient i.
    always_comb begin
        psum_d = '0;
        for (int i = 0; i < NTAPS; i++) begin
            if (plane_bits[i]) begin
                psum_d = psum_d + PSW'(COEFS[i*CW +: CW]);
            end
        end
    end

    // Capture the plane sum for the sample accepted this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psum_q <= '0;
        end else if (en) begin
            psum_q <= psum_d;
        end
    end

endmodule

// File: rtl/dafir_shift_add.sv
// Module dafir_shift_add
// Weights plane b by 2^b, adds all planes and registers the result when en
// is high. Assumes OW is wide enough for the weighted total (sized by the
// package helpers); the result holds while en is low.
module dafir_shift_add #(
    parameter int  DW  = 4,
    parameter int  PSW = 9,
    parameter int  OW  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DW*PSW-1:0] psums,
    output logic [OW-1:0]     result_q
);

    logic [OW-1:0] total_d;

    // Shift each plane sum by its bit position and accumulate.
    always_comb begin
        total_d = '0;
        for (int b = 0; b < DW; b++) begin
            total_d = total_d + (OW'(psums[b*PSW +: PSW]) << b);
        end
    end

    // Register the combined result for a valid stage-one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (en) begin
            result_q <= total_d;
        end
    end

endmodule

// File: rtl/dafir_filter.sv
// Module dafir_filter (top)
// Multiplierless unsigned FIR filter built from bit-plane partial sums.
// Stage 1 registers one partial sum per sample bit; stage 2 registers the
// shift-and-add result. A sample accepted at edge t yields out_valid after
// edge t+1. Assumes unsigned samples and coefficients; synchronous
// active-low reset.
module dafir_filter #(
    parameter int                   NTAPS = 16,
    parameter int                   DW    = 4,
    parameter int                   CW    = 4,
    parameter logic [NTAPS*CW-1:0]  COEFS = 64'hFEDC_BA98_7654_3210,
    localparam int                  PSW   = dafir_pkg::psum_width(NTAPS, CW),
    localparam int                  OW    = dafir_pkg::out_width(NTAPS, DW, CW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [OW-1:0] out_data
);

    logic [NTAPS*DW-1:0] taps;
    logic [NTAPS-1:0]    plane_bits [DW];
    logic [DW*PSW-1:0]   psums;
    logic                stage1_v_q;

    // Tap window: current sample plus delayed history.
    dafir_delay_line #(
        .NTAPS (NTAPS),
        .DW    (DW)
    ) delay_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .din   (in_data),
        .taps  (taps)
    );

    // One partial-sum unit per sample bit position.
    for (genvar b = 0; b < DW; b++) begin : g_plane
        for (genvar i = 0; i < NTAPS; i++) begin : g_bit
            assign plane_bits[b][i] = taps[i*DW + b];
        end

        dafir_plane_sum #(
            .NTAPS (NTAPS),
            .CW    (CW),
            .COEFS (COEFS)
        ) plane_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (in_valid),
            .plane_bits (plane_bits[b]),
            .psum_q     (psums[b*PSW +: PSW])
        );
    end

    // Valid tag that travels alongside the stage-one partial sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_v_q <= 1'b0;
        end else begin
            stage1_v_q <= in_valid;
        end
    end

    // Weighted combine of all planes into the result register.
    dafir_shift_add #(
        .DW  (DW),
        .PSW (PSW),
        .OW  (OW)
    ) combine_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (stage1_v_q),
        .psums    (psums),
        .result_q (out_data)
    );

    // Output strobe: one pulse per stage-one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= stage1_v_q;
        end
    end

endmodule

// File: rtl/dafir_filter_chk.sv
// Module dafir_filter_chk
// Port-level temporal checks for dafir_filter, attached through bind.
// Assumes the same parameters as the filter it watches.
module dafir_filter_chk #(
    parameter int                   NTAPS = 16,
    parameter int                   DW    = 4,
    parameter int                   CW    = 4,
    parameter logic [NTAPS*CW-1:0]  COEFS = '0,
    localparam int                  OW    = dafir_pkg::out_width(NTAPS, DW, CW),
    localparam int                  MAXV  = dafir_pkg::coef_total(
                                               dafir_pkg::MAX_COEF_BITS'(COEFS),
                                               NTAPS, CW) * ((1 << DW) - 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic [OW-1:0] out_data
);

    localparam logic [OW-1:0] MAXV_W = OW'(MAXV);

    logic armed = 1'b0;

    // Arms the history-based checks one full cycle after reset is released.
    always_ff @(posedge clk) begin
        armed <= rst_n;
    end

    // R1: a reset edge leaves the outputs cleared.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

    // R3: no result exceeds the largest possible sum.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data <= MAXV_W));

    // R4: an accepted sample produces a pulse two edges later.
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R4: every pulse traces back to an accepted sample.
    p_pulse_source_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        out_valid |-> $past(in_valid, 2));

    // R5: an idle input cycle produces no pulse.
    p_idle_no_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R7: the result holds between pulses.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !out_valid |-> $stable(out_data));

endmodule

bind dafir_filter dafir_filter_chk #(
    .NTAPS (NTAPS),
    .DW    (DW),
    .CW    (CW),
    .COEFS (COEFS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/dafir_filter_tb_top.sv
// Bench for dafir_filter: a behavioural model (sample queue plus integer
// convolution) is stepped on every rising edge, and the outputs are compared
// with it on every falling edge.
module dafir_filter_tb_top;

    localparam int NT = 16;
    localparam int OW = 13;
    localparam logic [63:0] TB_COEFS = 64'hDA6B_482F_5C91_F073;
    localparam int H [NT] = '{3, 7, 0, 15, 1, 9, 12, 5, 15, 2, 8, 4, 11, 6, 10, 13};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [3:0]    in_data = '0;
    logic          out_valid;
    logic [OW-1:0] out_data;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    chk_on = 1'b0;
    string tag = "R1";

    // Model state.
    int q_hist[$];
    bit m_v1 = 1'b0;
    bit m_v2 = 1'b0;
    int m_y1 = 0;
    int m_y2 = 0;

    dafir_filter #(
        .NTAPS (NT),
        .DW    (4),
        .CW    (4),
        .COEFS (TB_COEFS)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #2.5 clk = ~clk;

    // Behavioural model: two-edge latency, direct-form sum over the queue.
    always @(posedge clk) begin
        if (!rst_n) begin
            q_hist.delete();
            m_v1 = 1'b0;
            m_v2 = 1'b0;
            m_y1 = 0;
            m_y2 = 0;
        end else begin
            if (m_v1) m_y2 = m_y1;
            m_v2 = m_v1;
            if (in_valid) begin
                int acc;
                q_hist.push_front(int'(in_data));
                if (q_hist.size() > NT) void'(q_hist.pop_back());
                acc = 0;
                foreach (q_hist[i]) acc += H[i] * q_hist[i];
                m_y1 = acc;
            end
            m_v1 = in_valid;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (chk_on) begin
            n_cmp++;
            if (out_valid !== m_v2) begin
                n_bad++;
                $display("FAIL [%s] R4 out_valid act=%0b exp=%0b", tag, out_valid, m_v2);
            end
            n_cmp++;
            if (out_data !== OW'(m_y2)) begin
                n_bad++;
                if (m_v2)
                    $display("FAIL [%s] R2 out_data act=%0d exp=%0d", tag, out_data, m_y2);
                else
                    $display("FAIL [%s] R7 held out_data act=%0d exp=%0d", tag, out_data, m_y2);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL [watchdog] run did not finish act=%0d exp<=50000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check_val(input string t, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL [%s] explicit act=%0d exp=%0d", t, act, exp);
        end
    endtask

    task automatic send(input int x);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 4'(x);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 4'($urandom);
        end
    endtask

    initial begin
        // R1: reset state.
        tag = "R1";
        rst_n = 1'b0;
        in_data = 4'hF;
        repeat (3) @(negedge clk);
        chk_on = 1'b1;
        check_val("R1 out_valid", int'(out_valid), 0);
        check_val("R1 out_data", int'(out_data), 0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        idle(2);
        check_val("R7 idle after reset", int'(out_data), 0);

        // R1: first result depends on the first sample only (h0*5).
        send(5);
        idle(1);
        @(negedge clk);
        check_val("R1 first result", int'(out_data), H[0] * 5);
        check_val("R4 first pulse", int'(out_valid), 1);

        // R6: one impulse per bit plane, then zeros to trace the response.
        tag = "R6";
        for (int b = 0; b < 4; b++) begin
            send(1 << b);
            for (int k = 0; k < NT + 1; k++) send(0);
        end
        idle(3);

        // R2: random samples, continuous stream.
        tag = "R2";
        for (int k = 0; k < 80; k++) send(int'($urandom_range(0, 15)));
        idle(3);

        // R5: random gaps with garbage data while idle.
        tag = "R5";
        for (int k = 0; k < 120; k++) begin
            if ($urandom_range(0, 2) == 0) idle(int'($urandom_range(1, 4)));
            else send(int'($urandom_range(0, 15)));
        end
        idle(20);
        for (int k = 0; k < 20; k++) send(int'($urandom_range(0, 15)));
        idle(3);

        // R3: all-max samples give the largest sum without wrap.
        tag = "R3";
        for (int k = 0; k < NT + 4; k++) send(15);
        idle(1);
        @(negedge clk);
        check_val("R3 max sum", int'(out_data), 15 * 121);
        idle(3);

        // R1: reset mid-stream, then a fresh sample (h0*7).
        tag = "R1";
        for (int k = 0; k < 6; k++) send(int'($urandom_range(1, 15)));
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_data = 4'd9;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        idle(1);
        send(7);
        idle(1);
        @(negedge clk);
        check_val("R1 after mid reset", int'(out_data), H[0] * 7);
        idle(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule